// File: doc/BRIEF.md
# Exclusive Access Monitor Bank

This block keeps track of exclusive read/write pairs for a single memory port. It holds a fixed pool of eight monitors. An exclusive read arms a monitor with the requester's transaction ID and the address of the memory burst it falls in. A later exclusive write from the same ID to the same burst succeeds only if that monitor is still armed. Ordinary writes that complete, and exclusive writes that succeed, disarm every monitor whose burst they touch, whatever ID issued them.

The block observes the read and write address channels. For each write request it returns one response code on the cycle after the request. The burst granularity used for address comparison comes from a two-bit setting. It is read live on every comparison. If a read and a write arrive in the same cycle, the write's effect on the monitors is applied first, and the read then allocates against the monitors that remain.

Top module: `excl_mon_bank`

## Requirements
- R1: There are eight monitors. After reset, exclusive reads from distinct IDs fill free monitors lowest index first. When all eight are armed, a new ID replaces the monitor at a round-robin victim pointer. The pointer starts at slot 0 after reset and steps by one on each replacement, so the ninth distinct ID evicts the first one armed.
- R2: Addresses are compared per burst. `gran_sel` 00 selects 32 bytes, 01 selects 64 bytes, and 10 or 11 select 128 bytes. Address bits below the burst size are ignored.
- R3: An exclusive write whose ID and burst match an armed monitor responds EXOKAY (code 01). Any other non-erroring write responds OKAY (code 00).
- R4: Every write request gives exactly one response, with `resp_valid` high on the cycle after the request. `resp_code` is never 10.
- R5: A write flagged with `wr_decerr` responds DECERR (code 11) and leaves all monitors unchanged.
- R6: An exclusive read from an ID that already owns a monitor re-arms that same monitor with the new burst. It does not take a second monitor.
- R7: A completed ordinary write disarms every armed monitor whose burst it matches, whichever ID issued it. A write to a different burst leaves monitors armed.
- R8: A successful exclusive write disarms the monitor it matched, so a repeat of the same exclusive write responds OKAY. A failed exclusive write disarms nothing.
- R9: Reset disarms all monitors and drives `resp_valid` low.
- R10: A read with `rd_excl` low does not arm, re-arm or disarm any monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gran_sel | input | 2 | Burst granularity select: 00=32 B, 01=64 B, 1x=128 B |
| rd_valid | input | 1 | Read address request present |
| rd_excl | input | 1 | Read request is exclusive |
| rd_id | input | ID_W | Read transaction ID |
| rd_addr | input | ADDR_W | Read byte address |
| wr_valid | input | 1 | Write address request present |
| wr_excl | input | 1 | Write request is exclusive |
| wr_decerr | input | 1 | Write address failed decode |
| wr_id | input | ID_W | Write transaction ID |
| wr_addr | input | ADDR_W | Write byte address |
| resp_valid | output | 1 | Write response present |
| resp_code | output | 2 | 00 OKAY, 01 EXOKAY, 11 DECERR |

## Verification
On every cycle, the assertions check the response timing against write requests and the absence of the reserved code. They also check that decode errors map to DECERR, that EXOKAY only follows an exclusive, decodable write, and that no ID ever owns more than one monitor. Whether a given pair succeeds depends on the history of reads and writes. That covers granularity masking, clearing by other IDs' writes, re-arming, round-robin eviction and the inertness of plain reads and errored writes, and only the bench's ordered scenarios can show these.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_DECERR = 2'b11
    } resp_e;
endpackage

// File: rtl/excl_blk_match.sv
// Compares one query against every monitor: burst match and ID match.
module excl_blk_match #(
    parameter int N          = 8,
    parameter int ID_W       = 6,
    parameter int ADDR_W     = 32,
    parameter int BASE_SHIFT = 5
) (
    input  logic [N-1:0]             vld,
    input  logic [N-1:0][ID_W-1:0]   ids,
    input  logic [N-1:0][ADDR_W-1:0] addrs,
    input  logic [1:0]               gran_sel,
    input  logic [ID_W-1:0]          q_id,
    input  logic [ADDR_W-1:0]        q_addr,
    output logic [N-1:0]             blk_hit,
    output logic [N-1:0]             id_hit
);
    logic [ADDR_W-1:0] blk_mask;

    always_comb begin
        case (gran_sel)
            2'b00:   blk_mask = {ADDR_W{1'b1}} << BASE_SHIFT;
            2'b01:   blk_mask = {ADDR_W{1'b1}} << (BASE_SHIFT + 1);
            default: blk_mask = {ADDR_W{1'b1}} << (BASE_SHIFT + 2);
        endcase
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign blk_hit[g] = vld[g] && (((addrs[g] ^ q_addr) & blk_mask) == '0);
        assign id_hit[g]  = vld[g] && (ids[g] == q_id);
    end
endmodule

// File: rtl/excl_slot_pick.sv
// Chooses the monitor an exclusive read arms: owner, else lowest free, else victim.
module excl_slot_pick #(
    parameter int N    = 8,
    parameter int ID_W = 6,
    localparam int PTR_W = $clog2(N)
) (
    input  logic [N-1:0]           busy,
    input  logic [N-1:0][ID_W-1:0] ids,
    input  logic [ID_W-1:0]        q_id,
    input  logic [PTR_W-1:0]       victim,
    output logic [PTR_W-1:0]       slot,
    output logic                   use_victim,
    output logic [N-1:0]           owner_hit
);
    for (genvar g = 0; g < N; g++) begin : g_own
        assign owner_hit[g] = busy[g] && (ids[g] == q_id);
    end

    always_comb begin
        slot       = '0;
        use_victim = 1'b0;
        if (|owner_hit) begin
            for (int i = 0; i < N; i++) begin
                if (owner_hit[i]) slot = PTR_W'(i);
            end
        end else if (!(&busy)) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!busy[i]) slot = PTR_W'(i);
            end
        end else begin
            slot       = victim;
            use_victim = 1'b1;
        end
    end
endmodule

// File: rtl/excl_mon_bank.sv
module excl_mon_bank
    import excl_mon_pkg::*;
#(
    parameter int N_MON      = 8,
    parameter int ID_W       = 6,
    parameter int ADDR_W     = 32,
    parameter int BASE_SHIFT = 5,
    localparam int PTR_W = $clog2(N_MON)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        gran_sel,
    input  logic              rd_valid,
    input  logic              rd_excl,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    input  logic              wr_excl,
    input  logic              wr_decerr,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              resp_valid,
    output logic [1:0]        resp_code
);
    typedef struct packed {
        logic [N_MON-1:0]             vld;
        logic [N_MON-1:0][ID_W-1:0]   ids;
        logic [N_MON-1:0][ADDR_W-1:0] addrs;
        logic [PTR_W-1:0]             rr;
        logic                         rsp_v;
        resp_e                        rsp;
    } state_t;

    state_t st_d, st_q;

    logic [N_MON-1:0] w_blk, w_idm, w_own, clr, vld_mid, r_owner;
    logic             wr_ok, ex_pass, wr_commits, pick_rr;
    logic [PTR_W-1:0] pick;

    excl_blk_match #(
        .N(N_MON), .ID_W(ID_W), .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT)
    ) u_wmatch (
        .vld     (st_q.vld),
        .ids     (st_q.ids),
        .addrs   (st_q.addrs),
        .gran_sel(gran_sel),
        .q_id    (wr_id),
        .q_addr  (wr_addr),
        .blk_hit (w_blk),
        .id_hit  (w_idm)
    );

    assign w_own      = w_blk & w_idm;
    assign wr_ok      = wr_valid && !wr_decerr;
    assign ex_pass    = wr_ok && wr_excl && (|w_own);
    assign wr_commits = wr_ok && (!wr_excl || ex_pass);
    assign clr        = wr_commits ? w_blk : '0;
    assign vld_mid    = st_q.vld & ~clr;

    excl_slot_pick #(.N(N_MON), .ID_W(ID_W)) u_pick (
        .busy      (vld_mid),
        .ids       (st_q.ids),
        .q_id      (rd_id),
        .victim    (st_q.rr),
        .slot      (pick),
        .use_victim(pick_rr),
        .owner_hit (r_owner)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = vld_mid;
        st_d.rsp_v = wr_valid;
        st_d.rsp   = RESP_OKAY;
        if (wr_valid) begin
            if (wr_decerr)    st_d.rsp = RESP_DECERR;
            else if (ex_pass) st_d.rsp = RESP_EXOKAY;
        end
        if (rd_valid && rd_excl) begin
            st_d.vld[pick]   = 1'b1;
            st_d.ids[pick]   = rd_id;
            st_d.addrs[pick] = rd_addr;
            if (pick_rr) begin
                st_d.rr = (st_q.rr == PTR_W'(N_MON - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.rsp_v;
    assign resp_code  = st_q.rsp;

    // R4
    rsp_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> resp_valid);
    // R4
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !resp_valid);
    // R4
    no_slverr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code != 2'b10));
    // R5
    decerr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_decerr) |=> (resp_code == 2'b11));
    // R3
    exokay_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'b01) |-> $past(wr_excl && !wr_decerr));
    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_owner));
endmodule

// File: tb/excl_mon_bank_test.sv
module excl_mon_bank_test;
    localparam int CLK_P = 10;
    localparam int ID_W = 6;
    localparam int ADDR_W = 32;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [1:0]        gran_sel = 2'b00;
    logic              rd_valid = 0, rd_excl = 0;
    logic [ID_W-1:0]   rd_id = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              wr_valid = 0, wr_excl = 0, wr_decerr = 0;
    logic [ID_W-1:0]   wr_id = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              resp_valid;
    logic [1:0]        resp_code;

    int total = 0;
    int bad = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    excl_mon_bank uut (
        .clk(clk), .rst_n(rst_n), .gran_sel(gran_sel),
        .rd_valid(rd_valid), .rd_excl(rd_excl), .rd_id(rd_id), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_excl(wr_excl), .wr_decerr(wr_decerr),
        .wr_id(wr_id), .wr_addr(wr_addr),
        .resp_valid(resp_valid), .resp_code(resp_code)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic rd(input logic ex, input int id, input int addr);
        @(negedge clk);
        rd_valid = 1; rd_excl = ex; rd_id = ID_W'(id); rd_addr = ADDR_W'(addr);
        @(negedge clk);
        rd_valid = 0; rd_excl = 0;
    endtask

    task automatic wr(input logic ex, input logic de, input int id, input int addr,
                      input logic [1:0] exp, input string tag);
        @(negedge clk);
        wr_valid = 1; wr_excl = ex; wr_decerr = de;
        wr_id = ID_W'(id); wr_addr = ADDR_W'(addr);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        wr_valid = 0; wr_excl = 0; wr_decerr = 0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && resp_valid) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R4 unexpected response: actual=%0b expected=none", resp_code);
                end else begin
                    logic [1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (resp_code !== e) begin
                        bad++;
                        $display("FAIL %s: actual=%0b expected=%0b", t, resp_code, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        total++;
        if (resp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R9 reset resp_valid: actual=%0b expected=0", resp_valid);
        end
        // R3 / R8 basic pair then repeat
        rd(1, 1, 'h100);
        wr(1, 0, 1, 'h100, 2'b01, "R3 matched pair");
        wr(1, 0, 1, 'h100, 2'b00, "R8 repeat after success");
        wr(1, 0, 2, 'h180, 2'b00, "R3 no monitor");
        // R2 granularity 32
        rd(1, 3, 'h200);
        wr(1, 0, 3, 'h21F, 2'b01, "R2 same 32B burst");
        rd(1, 3, 'h200);
        wr(1, 0, 3, 'h220, 2'b00, "R2 next 32B burst");
        wr(1, 0, 3, 'h200, 2'b01, "R8 failed write keeps monitor");
        // R2 granularity 128 then 64
        gran_sel = 2'b10;
        rd(1, 4, 'h400);
        wr(1, 0, 4, 'h47C, 2'b01, "R2 same 128B burst");
        gran_sel = 2'b01;
        rd(1, 4, 'h400);
        wr(1, 0, 4, 'h440, 2'b00, "R2 outside 64B burst");
        wr(1, 0, 4, 'h43F, 2'b01, "R2 inside 64B burst");
        gran_sel = 2'b00;
        // R7 plain write clears, other burst does not
        rd(1, 5, 'h600);
        wr(0, 0, 9, 'h610, 2'b00, "R7 plain write");
        wr(1, 0, 5, 'h600, 2'b00, "R7 cleared by other id");
        rd(1, 6, 'h700);
        wr(0, 0, 9, 'h740, 2'b00, "R7 plain write elsewhere");
        wr(1, 0, 6, 'h700, 2'b01, "R7 untouched monitor");
        // R6 re-arm
        rd(1, 7, 'h800);
        rd(1, 7, 'h900);
        wr(1, 0, 7, 'h800, 2'b00, "R6 old burst dropped");
        wr(1, 0, 7, 'h900, 2'b01, "R6 new burst armed");
        // R5 decode error
        rd(1, 20, 'hA00);
        wr(1, 1, 20, 'hA00, 2'b11, "R5 decerr");
        wr(1, 0, 20, 'hA00, 2'b01, "R5 monitor untouched");
        // R8 failed exclusive from other id does not clear
        rd(1, 21, 'hB00);
        wr(1, 0, 22, 'hB00, 2'b00, "R8 wrong id fails");
        wr(1, 0, 21, 'hB00, 2'b01, "R8 owner still armed");
        // R10 plain read is inert
        rd(1, 23, 'hD00);
        rd(0, 23, 'hE00);
        wr(1, 0, 23, 'hD00, 2'b01, "R10 plain read ignored");
        // R9 reset disarms
        rd(1, 30, 'hC00);
        do_reset();
        wr(1, 0, 30, 'hC00, 2'b00, "R9 reset disarms");
        // R1 fill eight then evict slot 0
        for (int i = 0; i < 8; i++) rd(1, 10 + i, 'h1000 + 'h100 * i);
        rd(1, 18, 'h2000);
        wr(1, 0, 10, 'h1000, 2'b00, "R1 oldest evicted");
        wr(1, 0, 11, 'h1100, 2'b01, "R1 second kept");
        wr(1, 0, 18, 'h2000, 2'b01, "R1 newcomer armed");
        wr(1, 0, 17, 'h1700, 2'b01, "R1 last kept");
        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R4 missing responses: actual=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule